// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 44-bit nanosecond time of day that runs freely from the system clock. A numerically controlled oscillator drives it. Each clock, a 32-bit increment is added to an accumulator. That accumulator holds the nanosecond integer above 29 fraction bits, so the low 29 bits of the increment are fractions of a nanosecond. The default increment of 0x80000000 advances time by 4 ns per clock. Software trims the frequency by nudging the increment up or down. An increment of zero halts the clock. Time rolls over to zero past 0xFFFFFFFFFFF ns.

Software reaches the counter through a plain 32-bit word register port with four registers. The nanosecond time is split over three fields: the low nibble, the middle 32 bits and the top byte. Reading the top field also latches the middle field, so reading offset 0x08 and then offset 0x04 yields one consistent 44-bit value. The top field is written from write-data bits [15:8]. Read data is combinational from the address. The latch is taken at the clock edge on which the read strobe is high. There is no back-pressure: every access completes in one cycle. The full time value is also driven on a parallel output for local consumers.

Top module: `nco_tod_timer`

## Requirements
- R1: While reset is high, at the following clock edge the time becomes zero, the increment register becomes 0x80000000, and the latched middle value becomes zero.
- R2: On each clock with no time-field write, the 73-bit accumulator ({time[43:0], fraction[28:0]}) adds the zero-extended 32-bit increment. With 0x80000000 the time rises by exactly 4 ns per clock.
- R3: With an increment of zero and no writes, the time holds its value.
- R4: A write to offset 0x00 loads time[3:0] from write-data[3:0], keeps time[43:4], clears the fraction and skips that cycle's addition.
- R5: A write to offset 0x04 loads time[35:4] from write-data[31:0] and keeps the other time bits.
- R6: A write to offset 0x08 loads time[43:36] from write-data[15:8]. The other write-data bits have no effect.
- R7: Reading 0x00 returns time[3:0] in bits [3:0]. Reading 0x08 returns time[43:36] in bits [7:0]. All other read bits of these registers are zero.
- R8: Reading 0x04 returns the time[35:4] that was current on the most recent clock edge where the read strobe was high at offset 0x08.
- R9: From 0xFFFFFFFFFFF ns the time wraps through zero, modulo 2^44.
- R10: Fractional increments accumulate. With 0x10000000 (0.5 ns), the time rises by 1 ns every two clocks.
- R11: Offset 0x0C reads back the increment and a write there replaces it. Any address with bits [1:0] nonzero reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wen | input | 1 | Write strobe, one write per high cycle |
| reg_ren | input | 1 | Read strobe; at offset 0x08 it latches the middle field |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| tod_ns | output | 44 | Current nanosecond time |

## Verification
The counting path is tried with four increments, each telling a different fault apart:
- The default increment separates a correct integer alignment from a shifted one.
- A half-nanosecond increment exposes a lost fraction carry and a fraction not cleared on a field write.
- A zero increment shows whether the counter truly stops.
- A preset near full scale shows whether the rollover is correct.

Field writes use data with every unused bit set, so a wrong slice or a wrong shift on the top field shows up in the time value. The snapshot read is separated from a live read by letting many clocks pass between the two accesses.

// File: rtl/nco_tod_pkg.sv
package nco_tod_pkg;
  localparam int NS_W    = 44;
  localparam int FRAC_W  = 29;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int LOW_W   = 4;
  localparam int MID_W   = 32;
  localparam int TOP_W   = NS_W - LOW_W - MID_W;
  localparam int TOP_WR_LSB = 8;
  localparam int ACC_W   = NS_W + FRAC_W;

  localparam logic [ADDR_W-1:0] OFF_LOW = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_MID = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_TOP = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_INC = 4'hC;

  localparam logic [BUS_W-1:0] INC_DEFAULT = 32'h8000_0000;

  typedef struct packed {
    logic low;
    logic mid;
    logic top;
    logic inc;
  } wr_sel_t;
endpackage

// File: rtl/nco_accum.sv
module nco_accum
  import nco_tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  incr,
  input  logic              ld_low,
  input  logic              ld_mid,
  input  logic              ld_top,
  input  logic [LOW_W-1:0]  low_val,
  input  logic [MID_W-1:0]  mid_val,
  input  logic [TOP_W-1:0]  top_val,
  output logic [NS_W-1:0]   ns
);
  localparam int LOW_POS = FRAC_W;
  localparam int MID_POS = FRAC_W + LOW_W;
  localparam int TOP_POS = FRAC_W + LOW_W + MID_W;

  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (ld_low || ld_mid || ld_top) begin
      acc_d[FRAC_W-1:0] = '0;
      if (ld_low) acc_d[LOW_POS +: LOW_W] = low_val;
      if (ld_mid) acc_d[MID_POS +: MID_W] = mid_val;
      if (ld_top) acc_d[TOP_POS +: TOP_W] = top_val;
    end else begin
      acc_d = acc_q + {{(ACC_W-BUS_W){1'b0}}, incr};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  assign ns = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/nco_regs.sv
module nco_regs
  import nco_tod_pkg::*;
#(
  parameter logic [BUS_W-1:0] INC_RESET = INC_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  input  logic              ren,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [NS_W-1:0]   ns,
  output logic [BUS_W-1:0]  incr,
  output logic              ld_low,
  output logic              ld_mid,
  output logic              ld_top,
  output logic [LOW_W-1:0]  low_val,
  output logic [MID_W-1:0]  mid_val,
  output logic [TOP_W-1:0]  top_val,
  output logic [BUS_W-1:0]  rdata
);
  wr_sel_t           wsel;
  logic [MID_W-1:0]  snap_q;
  logic [BUS_W-1:0]  incr_q;

  always_comb begin
    wsel     = '0;
    wsel.low = wen && (addr == OFF_LOW);
    wsel.mid = wen && (addr == OFF_MID);
    wsel.top = wen && (addr == OFF_TOP);
    wsel.inc = wen && (addr == OFF_INC);
  end

  assign ld_low  = wsel.low;
  assign ld_mid  = wsel.mid;
  assign ld_top  = wsel.top;
  assign low_val = wdata[LOW_W-1:0];
  assign mid_val = wdata[MID_W-1:0];
  assign top_val = wdata[TOP_WR_LSB +: TOP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      incr_q <= INC_RESET;
      snap_q <= '0;
    end else begin
      if (wsel.inc) incr_q <= wdata;
      if (ren && (addr == OFF_TOP)) snap_q <= ns[LOW_W +: MID_W];
    end
  end

  assign incr = incr_q;

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFF_LOW: rdata[LOW_W-1:0] = ns[LOW_W-1:0];
      OFF_MID: rdata[MID_W-1:0] = snap_q;
      OFF_TOP: rdata[TOP_W-1:0] = ns[NS_W-1 -: TOP_W];
      OFF_INC: rdata            = incr_q;
      default: rdata            = '0;
    endcase
  end
endmodule

// File: rtl/nco_tod_timer.sv
module nco_tod_timer
  import nco_tod_pkg::*;
#(
  parameter logic [31:0] INC_RESET = INC_DEFAULT
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wen,
  input  logic        reg_ren,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [43:0] tod_ns
);
  logic [BUS_W-1:0] incr;
  logic             ld_low, ld_mid, ld_top;
  logic             time_wr;
  logic [LOW_W-1:0] low_val;
  logic [MID_W-1:0] mid_val;
  logic [TOP_W-1:0] top_val;

  nco_regs #(.INC_RESET(INC_RESET)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wen(reg_wen), .ren(reg_ren),
    .wdata(reg_wdata), .ns(tod_ns), .incr(incr),
    .ld_low(ld_low), .ld_mid(ld_mid), .ld_top(ld_top),
    .low_val(low_val), .mid_val(mid_val), .top_val(top_val),
    .rdata(reg_rdata)
  );

  nco_accum u_accum (
    .clk(clk), .rst(rst), .incr(incr),
    .ld_low(ld_low), .ld_mid(ld_mid), .ld_top(ld_top),
    .low_val(low_val), .mid_val(mid_val), .top_val(top_val),
    .ns(tod_ns)
  );

  assign time_wr = ld_low | ld_mid | ld_top;
endmodule

// File: rtl/nco_tod_checker.sv
module nco_tod_checker (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  reg_addr,
  input logic        reg_wen,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [43:0] tod_ns,
  input logic [31:0] incr,
  input logic        time_wr
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (tod_ns == 44'd0)); // R1

  AST_DEFAULT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!time_wr && incr == 32'h8000_0000) |=> (tod_ns == $past(tod_ns) + 44'd4)); // R2

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!time_wr && incr == 32'd0) |=> $stable(tod_ns)); // R3

  AST_MID_LOAD: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == 4'h4) |=> (tod_ns[35:4] == $past(reg_wdata))); // R5

  AST_TOP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == 4'h8) |=> (tod_ns[43:36] == $past(reg_wdata[15:8]))); // R6

  AST_TOP_READ_PAD: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 4'h8) |-> (reg_rdata[31:8] == 24'd0)); // R7

  AST_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr[1:0] != 2'b00) |-> (reg_rdata == 32'd0)); // R11
endmodule

bind nco_tod_timer nco_tod_checker u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tod_ns(tod_ns),
  .incr(incr), .time_wr(time_wr)
);

// File: tb/nco_tod_timer_test.sv
`timescale 1ns/1ps
module nco_tod_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = 4'h0;
  logic        reg_wen = 1'b0;
  logic        reg_ren = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [43:0] tod_ns;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nco_tod_timer uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_ren(reg_ren), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tod_ns(tod_ns)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [43:0] t);
    @(negedge clk);
    reg_addr = a; reg_ren = 1'b1;
    #1;
    d = reg_rdata; t = tod_ns;
    @(negedge clk);
    reg_ren = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [43:0] t;
    idle(3);
    chk("R1 time in reset", {20'd0, tod_ns}, 64'd0);
    @(negedge clk); reg_addr = 4'hC; #1;
    chk("R1 increment default", {32'd0, reg_rdata}, 64'h8000_0000);
    reg_addr = 4'h4; #1;
    chk("R1 snapshot cleared", {32'd0, reg_rdata}, 64'd0);
    rst = 1'b0;
    idle(10);
    chk("R2 default 4 ns per clock", {20'd0, tod_ns}, 64'd40);
    rd(4'h0, d, t);
    chk("R7 low field read", {32'd0, d}, {60'd0, t[3:0]});
  endtask

  task automatic t_fields();
    logic [31:0] d; logic [43:0] t;
    wr(4'hC, 32'h0);
    wr(4'h4, 32'h1234_5678);
    chk("R5 middle field load", {20'd0, tod_ns[35:4]}, {32'd0, 32'h1234_5678});
    wr(4'h8, 32'hFFFF_AB55);
    chk("R6 top field from bits 15:8", {56'd0, tod_ns[43:36]}, 64'hAB);
    wr(4'h0, 32'hFFFF_FFF9);
    chk("R4 low field load", {20'd0, tod_ns}, {20'd0, 44'hAB_1234_5678_9});
    idle(6);
    chk("R3 zero increment holds time", {20'd0, tod_ns}, {20'd0, 44'hAB_1234_5678_9});
    rd(4'h8, d, t);
    chk("R7 top field read", {32'd0, d}, 64'hAB);
    rd(4'h4, d, t);
    chk("R8 middle after top read", {32'd0, d}, 64'h1234_5678);
    rd(4'hC, d, t);
    chk("R11 increment read back", {32'd0, d}, 64'd0);
    rd(4'h2, d, t);
    chk("R11 unaligned read zero", {32'd0, d}, 64'd0);
    wr(4'h6, 32'h0);
    wr(4'hE, 32'h5);
    chk("R11 unaligned write ignored", {20'd0, tod_ns}, {20'd0, 44'hAB_1234_5678_9});
    rd(4'hC, d, t);
    chk("R11 increment untouched by unaligned write", {32'd0, d}, 64'd0);
  endtask

  task automatic t_snapshot();
    logic [31:0] d; logic [43:0] t0, t1;
    wr(4'hC, 32'h8000_0000);
    rd(4'h8, d, t0);
    idle(40);
    rd(4'h4, d, t1);
    chk("R8 snapshot coherent", {32'd0, d}, {32'd0, t0[35:4]});
    chk("R8 time moved meanwhile", {32'd0, d == t1[35:4]}, 64'd0);
  endtask

  task automatic t_wrap();
    wr(4'hC, 32'h0);
    wr(4'h8, 32'h0000_FF00);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h0, 32'h0000_000F);
    chk("R9 preset full scale", {20'd0, tod_ns}, {20'd0, 44'hFFF_FFFF_FFFF});
    wr(4'hC, 32'h8000_0000);
    chk("R9 no step on increment write", {20'd0, tod_ns}, {20'd0, 44'hFFF_FFFF_FFFF});
    @(negedge clk);
    chk("R9 wrap through zero", {20'd0, tod_ns}, 64'd3);
  endtask

  task automatic t_fraction();
    wr(4'hC, 32'h0);
    wr(4'h8, 32'h0);
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h0);
    wr(4'hC, 32'h1000_0000);
    idle(5);
    chk("R10 half ns step after 5 clocks", {20'd0, tod_ns}, 64'd2);
    idle(6);
    chk("R10 half ns step after 11 clocks", {20'd0, tod_ns}, 64'd5);
    wr(4'h0, 32'h0);
    chk("R4 low write value", {20'd0, tod_ns}, 64'd0);
    @(negedge clk);
    chk("R4 fraction cleared by write", {20'd0, tod_ns}, 64'd0);
    @(negedge clk);
    chk("R10 carry after two halves", {20'd0, tod_ns}, 64'd1);
  endtask

  initial begin
    t_reset();
    t_fields();
    t_snapshot();
    t_wrap();
    t_fraction();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule